// File: doc/BRIEF.md
# Ordering Table Clear DMA Channel

This block is a single DMA channel that does one job: it fills a region of memory with a linked chain that runs downward. Software programs a base address, a word count and a control word through a small register port. When the transfer runs, the channel writes one word per granted clock. It starts at the word-aligned base address and moves down by four bytes on each write. Each word it writes holds the 24-bit address of the word just below it. The lowest word holds the end marker 00FFFFFFh. The result is a ready-made empty linked list that a later list walker can follow from the top entry down to the marker.

The channel has a plain word-write master port. The memory side says which clocks the channel may use by raising `memGrant`. The channel answers with `memWrEn`, an address and a data word in that same cycle. A transfer waits until the busy bit is set and either the force bit is set or the external enable input is high. When the last word is written, the channel clears its busy bit. In the same cycle it raises a one-clock `donePulse` that goes to an interrupt block.

Top module: `orderTableDma`

## Requirements
- R1: After reset the base readback is 0, the count readback is 0, the control readback is 00000002h, and `memWrEn` and `donePulse` are low.
- R2: `regSel`=0 writes the base register. Its readback shows bits 23:0 exactly as written, including bits 1:0. Bits 31:24 read as zero.
- R3: `regSel`=2 writes the control register. Only bit 24 (busy/start), bit 28 (force) and bit 30 (snoop) store a value. Bit 1 always reads 1. Every other bit reads 0.
- R4: No memory write occurs while busy is clear. No memory write occurs while busy is set but force and `extEnable` are both low. Once a transfer begins, the force bit reads 0.
- R5: The first write goes to the base address with bits 1:0 forced to zero. Each clock with `memGrant` high writes one word, and each write is 4 below the previous address. A clock with `memGrant` low writes nothing.
- R6: Every word except the last is written with (its own address − 4) & FFFFFFh. The last word, at the lowest address, is written with 00FFFFFFh.
- R7: `regSel`=1 writes the 16-bit count. A transfer writes exactly that many words, and a count of 0 means 65536 words.
- R8: The address wraps from 000000h down to FFFFFCh while the count is not yet used up.
- R9: Busy reads 0 on the clock after the last write. `donePulse` is high for exactly that one clock.
- R10: Control writes made while a transfer is running are ignored. The transfer changes neither the base readback nor the count readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 base, 1 count, 2 control, 3 none |
| regWrData | input | 32 | Register write data |
| baseAddrOut | output | 32 | Base register readback |
| countOut | output | 32 | Count register readback |
| ctrlOut | output | 32 | Control register readback |
| extEnable | input | 1 | External run enable, used when force is clear |
| memGrant | input | 1 | Memory port is available this clock |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 24 | Memory word address |
| memData | output | 32 | Memory write data |
| donePulse | output | 1 | One-clock completion pulse |

## Verification
A register write shows on its readback one clock after the write edge. The transfer begins on the edge after the start condition. From that edge on, `memWrEn`, `memAddr` and `memData` respond in the same cycle as `memGrant`, with no register in between. Busy clearing and `donePulse` both appear one edge after the last granted write. The bench drives each stimulus at a falling edge and samples the outputs 1 ns later. Memory outputs are compared in the same half-cycle in which `memGrant` was raised. Readbacks and the done pulse are checked at the falling edge after the edge that should change them.

// File: rtl/otcPkg.sv
package otcPkg;
  localparam logic [1:0] SEL_BASE  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int BIT_STEP_DN = 1;
  localparam int BIT_BUSY    = 24;
  localparam int BIT_FORCE   = 28;
  localparam int BIT_SNOOP   = 30;

  typedef struct packed {
    logic load;
    logic step;
  } otcStrobe_t;
endpackage

// File: rtl/otcControl.sv
module otcControl
  import otcPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              extEnable,
  input  logic              memGrant,
  input  logic              isLast,
  output otcStrobe_t        strobe,
  output logic [ADDR_W-1:0] baseReg,
  output logic [CNT_W-1:0]  countReg,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              donePulse
);
  logic busyFlag, forceFlag, snoopFlag, running;
  logic ctrlWrite, startNow, lastStep;

  always_comb begin
    ctrlWrite   = regWrEn && (regSel == SEL_CTRL);
    startNow    = busyFlag && !running && (forceFlag || extEnable) && !ctrlWrite;
    strobe.load = startNow;
    strobe.step = running && memGrant;
    lastStep    = strobe.step && isLast;
  end

  always_comb begin
    ctrlOut              = '0;
    ctrlOut[BIT_STEP_DN] = 1'b1;
    ctrlOut[BIT_BUSY]    = busyFlag;
    ctrlOut[BIT_FORCE]   = forceFlag;
    ctrlOut[BIT_SNOOP]   = snoopFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg   <= '0;
      countReg  <= '0;
      busyFlag  <= 1'b0;
      forceFlag <= 1'b0;
      snoopFlag <= 1'b0;
      running   <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= lastStep;
      if (regWrEn && regSel == SEL_BASE)  baseReg  <= regWrData[ADDR_W-1:0];
      if (regWrEn && regSel == SEL_COUNT) countReg <= regWrData[CNT_W-1:0];
      if (ctrlWrite && !running) begin
        busyFlag  <= regWrData[BIT_BUSY];
        forceFlag <= regWrData[BIT_FORCE];
        snoopFlag <= regWrData[BIT_SNOOP];
      end else if (startNow) begin
        running   <= 1'b1;
        forceFlag <= 1'b0;
      end else if (lastStep) begin
        running   <= 1'b0;
        busyFlag  <= 1'b0;
      end
    end
  end

  // R4
  start_clears_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> running && !forceFlag);

  // R4
  step_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> busyFlag);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busyFlag && !running);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && !lastStep |=> busyFlag && running);
endmodule

// File: rtl/otcDatapath.sv
module otcDatapath
  import otcPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  otcStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [CNT_W-1:0]  countReg,
  output logic              isLast,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int REM_W = CNT_W + 1;
  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] END_MARK  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
  localparam logic [REM_W-1:0]  FULL_CNT  = REM_W'(1) << CNT_W;

  logic [ADDR_W-1:0] curAddr;
  logic [REM_W-1:0]  remaining;
  logic [ADDR_W-1:0] linkAddr;

  always_comb begin
    isLast   = (remaining == REM_W'(1));
    linkAddr = isLast ? END_MARK : (curAddr - WORD_STEP);
    memAddr  = curAddr;
    memData  = {{PAD_W{1'b0}}, linkAddr};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remaining <= '0;
    end else if (strobe.load) begin
      curAddr   <= {baseReg[ADDR_W-1:2], 2'b00};
      remaining <= (countReg == '0) ? FULL_CNT : {1'b0, countReg};
    end else if (strobe.step) begin
      curAddr   <= curAddr - WORD_STEP;
      remaining <= remaining - REM_W'(1);
    end
  end

  // R5
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> curAddr[1:0] == 2'b00);

  // R7
  count_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> remaining != '0);

  // R6
  link_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !isLast |-> memData[1:0] == 2'b00);
endmodule

// File: rtl/orderTableDma.sv
module orderTableDma
  import otcPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] baseAddrOut,
  output logic [DATA_W-1:0] countOut,
  output logic [DATA_W-1:0] ctrlOut,
  input  logic              extEnable,
  input  logic              memGrant,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              donePulse
);
  otcStrobe_t        strobe;
  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  countReg;
  logic              isLast;

  otcControl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) ctrlUnit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .extEnable(extEnable), .memGrant(memGrant),
    .isLast(isLast), .strobe(strobe), .baseReg(baseReg), .countReg(countReg),
    .ctrlOut(ctrlOut), .donePulse(donePulse)
  );

  otcDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) pathUnit (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseReg(baseReg),
    .countReg(countReg), .isLast(isLast), .memAddr(memAddr), .memData(memData)
  );

  assign memWrEn     = strobe.step;
  assign baseAddrOut = {{(DATA_W-ADDR_W){1'b0}}, baseReg};
  assign countOut    = {{(DATA_W-CNT_W){1'b0}}, countReg};

  // R5
  write_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memGrant && ctrlOut[BIT_BUSY]);
endmodule

// File: tb/orderTableDma_test.sv
`timescale 1ns/1ps
module orderTableDma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [31:0] regWrData = '0;
  logic [31:0] baseAddrOut, countOut, ctrlOut, memData;
  logic        extEnable = 1'b0, memGrant = 1'b0, memWrEn, donePulse;
  logic [23:0] memAddr;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  orderTableDma uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .baseAddrOut(baseAddrOut), .countOut(countOut),
    .ctrlOut(ctrlOut), .extEnable(extEnable), .memGrant(memGrant),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData), .donePulse(donePulse)
  );

  // {base[23:0], count[15:0], useForce, gappyGrant}
  localparam logic [41:0] VEC [5] = '{
    {24'h000100, 16'd5, 1'b1, 1'b0},
    {24'h000013, 16'd3, 1'b0, 1'b1},
    {24'h000008, 16'd4, 1'b1, 1'b1},
    {24'h7FFFFC, 16'd1, 1'b0, 1'b0},
    {24'h100000, 16'd0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regSel = 2'd3;
    #1;
  endtask

  // Runs one started transfer to completion, checking each written word.
  task automatic runAndCheck(input logic [23:0] base, input int n, input logic gappy);
    logic [23:0] expAddr = {base[23:2], 2'b00};
    int          seen = 0;
    logic        doneSeen = 1'b0;
    int          badWords = 0;
    for (int cyc = 0; cyc < 70000 && !doneSeen; cyc++) begin
      @(negedge clk);
      if (donePulse) begin
        doneSeen = 1'b1;
        check("R9 busy clear with done", {31'b0, ctrlOut[24]}, 32'd0);
      end else begin
        memGrant = gappy ? (cyc % 3 != 2) : 1'b1;
        #1;
        if (!memGrant) check("R5 no write without grant", {31'b0, memWrEn}, 32'd0);
        if (memWrEn) begin
          logic [23:0] expLink = (seen == n - 1) ? 24'hFFFFFF : expAddr - 24'd4;
          if (memAddr !== expAddr || memData !== {8'h00, expLink}) begin
            badWords++;
            if (badWords < 4) begin
              check("R5 R6 R8 word address", {8'h00, memAddr}, {8'h00, expAddr});
              check("R6 word data", memData, {8'h00, expLink});
            end
          end
          expAddr = expAddr - 24'd4;
          seen++;
        end
      end
    end
    memGrant = 1'b0;
    checks++;
    if (badWords != 0) begin
      errors++;
      $display("FAIL R6 bad words actual=%0d expected=0", badWords);
    end
    check("R7 word count", seen, n);
    check("R9 done seen", {31'b0, doneSeen}, 32'd1);
    @(negedge clk);
    check("R9 done one cycle", {31'b0, donePulse}, 32'd0);
    check("R4 force cleared, idle ctrl", ctrlOut, 32'h00000002);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 base", baseAddrOut, 32'h0);
    check("R1 count", countOut, 32'h0);
    check("R1 ctrl", ctrlOut, 32'h00000002);
    check("R1 wr/done", {30'b0, memWrEn, donePulse}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 address register width and low bits
    regWrite(2'd0, 32'hABCDEF13);
    check("R2 base readback", baseAddrOut, 32'h00CDEF13);
    // R3 writable control bits only (bit 24 left clear)
    regWrite(2'd2, 32'hFEFFFFFF);
    check("R3 ctrl readback", ctrlOut, 32'h50000002);
    regWrite(2'd2, 32'h0);
    check("R3 ctrl cleared", ctrlOut, 32'h00000002);

    // Vector table walk
    for (int v = 0; v < 5; v++) begin
      logic [23:0] base = VEC[v][41:18];
      logic [15:0] cnt  = VEC[v][17:2];
      int n = (cnt == 0) ? 65536 : int'(cnt);
      regWrite(2'd0, {8'h00, base});
      regWrite(2'd1, {16'h0, cnt});
      if (!VEC[v][1]) extEnable = 1'b1;
      regWrite(2'd2, VEC[v][1] ? 32'h11000000 : 32'h01000000);
      runAndCheck(base, n, VEC[v][0]);
      extEnable = 1'b0;
      // R10 transfer leaves base and count registers alone
      check("R10 base kept", baseAddrOut, {8'h00, base});
      check("R10 count kept", countOut, {16'h0, cnt});
    end

    // R4 busy without force or enable: no writes
    regWrite(2'd0, 32'h00000040);
    regWrite(2'd1, 32'd2);
    regWrite(2'd2, 32'h01000000);
    memGrant = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check("R4 no write while gated", {31'b0, memWrEn}, 32'd0);
    end
    check("R4 still busy", ctrlOut, 32'h01000002);
    memGrant = 1'b0;
    extEnable = 1'b1;
    @(negedge clk);
    extEnable = 1'b0;
    // R10 control write of zero during the run is ignored
    regWrite(2'd2, 32'h0);
    check("R10 busy kept", ctrlOut, 32'h01000002);
    runAndCheck(24'h000040, 2, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule